// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Selectable Final Adder

This block is an unsigned multiply-accumulate datapath. On every enabled clock it multiplies two N-bit operands and adds the product to a (2N+1)-bit accumulator register. The result wraps modulo 2^(2N+1) and sets no flag. A synchronous clear zeroes the accumulator. When the enable is low, the accumulator holds its value.

Inside, the operand bits form N shifted partial-product rows. The current accumulator value is added as one more row. A linear array of carry-save stages compresses all N+1 rows into a sum row and a carry row. One carry-propagate adder then resolves those two rows into the next accumulator value, so each cycle makes only one carry-propagate addition.

The parameter `ADDER_KIND` selects the structure of that final adder at compile time:
- 0: group look-ahead.
- 1: carry select over a low half and a duplicated high half.
- 2: carry skip with equal-size groups.

All three give bit-identical results behind the same ports. Designers pick one by timing and area without touching the surrounding logic.

Top module: `mac_unit`

## Requirements
- R1: When `clear` is 1 at a rising edge, `accOut` is 0 after that edge, whatever `enable`, `opA` and `opB` are (clear has priority over enable).
- R2: When `clear` is 0 and `enable` is 0 at a rising edge, `accOut` keeps its value, whatever `opA` and `opB` are.
- R3: When `clear` is 0 and `enable` is 1 at a rising edge, `accOut` becomes (previous `accOut` + `opA`*`opB`) mod 2^(2N+1), with both operands treated as unsigned.
- R4: The accumulator wraps modulo 2^(2N+1) without saturating. With N=8, three enabled cycles of 255*255 after a clear leave `accOut` = 64003.
- R5: With `ADDER_KIND` = 0 (group look-ahead, group size `GROUP`), the unit meets R1 to R4.
- R6: With `ADDER_KIND` = 1 (carry select, low half of floor((2N+1)/2) bits), the unit meets R1 to R4.
- R7: With `ADDER_KIND` = 2 (carry skip, group size `GROUP`), the unit meets R1 to R4.
- R8: All three adder kinds produce the same `accOut` on every cycle for the same input sequence. Each final adder's output equals the modular sum of its two input rows.
- R9: The two carry-save rows handed to the final adder sum, modulo 2^(2N+1), to the current accumulator value plus `opA`*`opB`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| clear | input | 1 | Synchronous clear of the accumulator; overrides enable |
| enable | input | 1 | Accumulate opA*opB into the register this cycle |
| opA | input | N | Unsigned multiplier operand |
| opB | input | N | Unsigned multiplicand operand |
| accOut | output | 2N+1 | Accumulator register value |

## Verification
Several properties hold on every cycle and are checked continuously:
- The carry-save rows preserve the arithmetic sum (R9).
- The selected final adder returns the exact modular sum of its rows (R8).
- The register clears, holds or accumulates as the strobes demand (R1, R2, R3).
- The clear and load strobes are never active together.

The bench runs all three adder kinds side by side against an arithmetic model. It sweeps every operand pair of the 8-bit configuration, so wraparound happens many times. Only these scenarios can show that the variants agree with each other and with the model over long sequences. They also cover the specific wrap value after repeated maxima and the priority of clear over enable.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int unsigned ADD_LOOKAHEAD = 0;
  localparam int unsigned ADD_SELECT    = 1;
  localparam int unsigned ADD_SKIP      = 2;

  typedef struct packed {
    logic clr;
    logic load;
  } macStrobes_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clear,
  input  logic        enable,
  output macStrobes_t strobes
);

  // Clear wins over enable; at most one strobe is active.
  always_comb begin
    strobes.clr  = clear;
    strobes.load = enable & ~clear;
  end

endmodule

// File: rtl/mac_ripple.sv
module mac_ripple #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);

  logic [WIDTH:0] chain;

  assign chain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic prop;
    logic gen;
    assign prop        = addA[i] ^ addB[i];
    assign gen         = addA[i] & addB[i];
    assign sumOut[i]   = prop ^ chain[i];
    assign chain[i+1]  = gen | (prop & chain[i]);
  end

  assign carryOut = chain[WIDTH];

endmodule

// File: rtl/mac_final_adder.sv
module mac_final_adder #(
  parameter int unsigned WIDTH = 17,
  parameter int unsigned GROUP = 4,
  parameter int unsigned KIND  = 0
) (
  input  logic [WIDTH-1:0] rowS,
  input  logic [WIDTH-1:0] rowC,
  output logic [WIDTH-1:0] total
);

  localparam int unsigned NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int unsigned LOW  = WIDTH / 2;
  localparam int unsigned HIGH = WIDTH - LOW;

  if (KIND == mac_pkg::ADD_LOOKAHEAD) begin : g_lookahead
    logic [WIDTH-1:0] prop, gen;
    logic [NGRP-1:0]  grpGen, grpProp;
    logic [NGRP:0]    grpCarry;

    assign prop = rowS ^ rowC;
    assign gen  = rowS & rowC;

    always_comb begin
      logic cr;
      // Group generate and propagate from each block of bits.
      for (int k = 0; k < NGRP; k++) begin
        grpGen[k]  = 1'b0;
        grpProp[k] = 1'b1;
        for (int j = 0; j < GROUP; j++) begin
          if (k * GROUP + j < WIDTH) begin
            grpGen[k]  = gen[k*GROUP+j] | (prop[k*GROUP+j] & grpGen[k]);
            grpProp[k] = grpProp[k] & prop[k*GROUP+j];
          end
        end
      end
      // Carries between groups come from group signals only.
      grpCarry[0] = 1'b0;
      for (int k = 0; k < NGRP; k++) begin
        grpCarry[k+1] = grpGen[k] | (grpProp[k] & grpCarry[k]);
      end
      // Carries inside each group start from its look-ahead carry.
      total = '0;
      for (int k = 0; k < NGRP; k++) begin
        cr = grpCarry[k];
        for (int j = 0; j < GROUP; j++) begin
          if (k * GROUP + j < WIDTH) begin
            total[k*GROUP+j] = prop[k*GROUP+j] ^ cr;
            cr = gen[k*GROUP+j] | (prop[k*GROUP+j] & cr);
          end
        end
      end
    end

  end else if (KIND == mac_pkg::ADD_SELECT) begin : g_select
    logic [LOW-1:0]  lowSum;
    logic            lowCarry;
    logic [HIGH-1:0] hiSum0, hiSum1;
    logic            hiCarry0, hiCarry1;

    mac_ripple #(.WIDTH(LOW)) u_low (
      .addA(rowS[LOW-1:0]), .addB(rowC[LOW-1:0]), .carryIn(1'b0),
      .sumOut(lowSum), .carryOut(lowCarry));

    mac_ripple #(.WIDTH(HIGH)) u_hi0 (
      .addA(rowS[WIDTH-1:LOW]), .addB(rowC[WIDTH-1:LOW]), .carryIn(1'b0),
      .sumOut(hiSum0), .carryOut(hiCarry0));

    mac_ripple #(.WIDTH(HIGH)) u_hi1 (
      .addA(rowS[WIDTH-1:LOW]), .addB(rowC[WIDTH-1:LOW]), .carryIn(1'b1),
      .sumOut(hiSum1), .carryOut(hiCarry1));

    logic unusedCarry;
    assign unusedCarry = lowCarry ? hiCarry1 : hiCarry0;
    assign total = {(lowCarry ? hiSum1 : hiSum0), lowSum};

  end else begin : g_skip
    logic [WIDTH-1:0] prop, gen;

    assign prop = rowS ^ rowC;
    assign gen  = rowS & rowC;

    always_comb begin
      logic cr;
      logic grpIn;
      logic allProp;
      cr = 1'b0;
      total = '0;
      for (int k = 0; k < NGRP; k++) begin
        grpIn   = cr;
        allProp = 1'b1;
        for (int j = 0; j < GROUP; j++) begin
          if (k * GROUP + j < WIDTH) begin
            total[k*GROUP+j] = prop[k*GROUP+j] ^ cr;
            cr      = gen[k*GROUP+j] | (prop[k*GROUP+j] & cr);
            allProp = allProp & prop[k*GROUP+j];
          end
        end
        // Bypass: a fully propagating group forwards its input carry.
        cr = allProp ? grpIn : cr;
      end
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned GROUP = 4,
  parameter int unsigned KIND  = 0
) (
  input  logic        clk,
  input  macStrobes_t strobes,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [2*N:0] accQ
);

  localparam int unsigned W = 2 * N + 1;

  logic [W-1:0] rows [N+1];
  logic [W-1:0] sumArr [N];
  logic [W-1:0] carArr [N];
  logic [W-1:0] nextAcc;
  logic [W-1:0] wideA;

  assign wideA = {{(W-N){1'b0}}, opA};

  // Partial-product rows plus the accumulator as the last row.
  for (genvar i = 0; i < N; i++) begin : g_pp
    assign rows[i] = opB[i] ? (wideA << i) : '0;
  end
  assign rows[N] = accQ;

  // Linear carry-save array: two rows in, one new row folded per stage.
  assign sumArr[0] = rows[0];
  assign carArr[0] = rows[1];
  for (genvar k = 1; k < N; k++) begin : g_csa
    assign sumArr[k] = sumArr[k-1] ^ carArr[k-1] ^ rows[k+1];
    assign carArr[k] = ((sumArr[k-1] & carArr[k-1]) |
                        (sumArr[k-1] & rows[k+1])   |
                        (carArr[k-1] & rows[k+1])) << 1;
  end

  mac_final_adder #(.WIDTH(W), .GROUP(GROUP), .KIND(KIND)) u_final (
    .rowS(sumArr[N-1]), .rowC(carArr[N-1]), .total(nextAcc));

  always_ff @(posedge clk) begin
    if (strobes.clr)       accQ <= '0;
    else if (strobes.load) accQ <= nextAcc;
  end

  // R9: compressed rows keep the arithmetic sum of accumulator and product.
  assert_tree_sum_R9: assert property (@(posedge clk) disable iff (strobes.clr)
    W'(sumArr[N-1] + carArr[N-1]) == W'(accQ + opA * opB));

  // R8: the selected final adder is exact modulo 2^W.
  assert_adder_exact_R8: assert property (@(posedge clk) disable iff (strobes.clr)
    nextAcc == W'(sumArr[N-1] + carArr[N-1]));

  // R1: clear and load never coincide; clear leaves zero behind.
  assert_strobe_excl_R1: assert property (@(posedge clk)
    $onehot0({strobes.clr, strobes.load}));
  assert_clear_zero_R1: assert property (@(posedge clk)
    strobes.clr |=> accQ == '0);

  // R2: no strobe, no change.
  assert_hold_R2: assert property (@(posedge clk) disable iff (strobes.clr)
    !strobes.load |=> $stable(accQ));

  // R3: a load adds the product of the previous cycle's operands.
  assert_accumulate_R3: assert property (@(posedge clk) disable iff (strobes.clr)
    strobes.load |=> accQ == W'($past(accQ) + $past(opA) * $past(opB)));

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned N          = 8,
  parameter int unsigned GROUP      = 4,
  parameter int unsigned ADDER_KIND = 0
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         enable,
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  output logic [2*N:0] accOut
);

  macStrobes_t strobes;

  mac_ctrl u_ctrl (
    .clear(clear), .enable(enable), .strobes(strobes));

  mac_datapath #(.N(N), .GROUP(GROUP), .KIND(ADDER_KIND)) u_dp (
    .clk(clk), .strobes(strobes), .opA(opA), .opB(opB), .accQ(accOut));

endmodule

// File: tb/mac_unit_tb.sv
`timescale 1ns/1ps
module mac_unit_tb;

  localparam int unsigned N = 8;
  localparam int unsigned W = 2 * N + 1;

  logic clk = 1'b0;
  logic clear = 1'b1;
  logic enable = 1'b0;
  logic [N-1:0] opA = '0;
  logic [N-1:0] opB = '0;
  logic [W-1:0] accLa, accSel, accSkip;
  logic [W-1:0] model = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mac_unit #(.N(N), .GROUP(4), .ADDER_KIND(0)) u_dut (
    .clk(clk), .clear(clear), .enable(enable), .opA(opA), .opB(opB), .accOut(accLa));
  mac_unit #(.N(N), .GROUP(4), .ADDER_KIND(1)) u_dut_sel (
    .clk(clk), .clear(clear), .enable(enable), .opA(opA), .opB(opB), .accOut(accSel));
  mac_unit #(.N(N), .GROUP(4), .ADDER_KIND(2)) u_dut_skip (
    .clk(clk), .clear(clear), .enable(enable), .opA(opA), .opB(opB), .accOut(accSkip));

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({"R5 ", tag}, accLa, model);
    check({"R6 ", tag}, accSel, model);
    check({"R7 ", tag}, accSkip, model);
    check({"R8 ", tag}, accSel, accLa);
  endtask

  // Drive on the falling edge, update the model at the rising edge, sample 1 ns later.
  task automatic step(input logic c, input logic e, input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    clear = c; enable = e; opA = a; opB = b;
    @(posedge clk);
    if (c) model = '0;
    else if (e) model = W'(model + a * b);
    #1;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1'b1, 1'b0, '0, '0);
    checkAll("R1 reset state");

    step(1'b0, 1'b1, 8'd13, 8'd11);
    checkAll("R3 single product");
    check("R3 literal", accLa, 17'd143);

    step(1'b0, 1'b0, 8'd255, 8'd255);
    checkAll("R2 hold with operands");
    check("R2 literal", accSel, 17'd143);
    step(1'b0, 1'b0, 8'd7, 8'd9);
    checkAll("R2 hold again");

    step(1'b1, 1'b1, 8'd200, 8'd100);
    checkAll("R1 clear over enable");
    check("R1 literal", accSkip, 17'd0);

    for (int r = 0; r < 3; r++) begin
      step(1'b0, 1'b1, 8'd255, 8'd255);
      checkAll("R4 repeated maxima");
    end
    check("R4 wrap literal", accLa, 17'd64003);

    step(1'b0, 1'b1, 8'd0, 8'd255);
    checkAll("R3 zero operand");

    step(1'b1, 1'b0, '0, '0);
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        step(1'b0, 1'b1, a[N-1:0], b[N-1:0]);
        checkAll("R3/R4/R9 sweep");
      end
      if (a % 64 == 63) begin
        step(1'b0, 1'b0, 8'd255, 8'd1);
        checkAll("R2 hold in sweep");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule